// File: doc/BRIEF.md
# Nonvolatile Memory Write-Sequence Controller

This block is the command front end of an on-chip nonvolatile memory. Software first loads a five-bit mode register, then issues ordinary 32-bit word writes into the memory window. The block decodes the mode bits into one of six operations and checks every address against the alignment and region rules of that operation. It collects the words of the operation in a load buffer. After the last word it runs a fixed-length busy period and then applies the result to a modelled memory array.

The window is a program area followed by a small data area. The program area is split into two equal banks, and each bank is made of pages of two half-pages. With the default parameters, bank 1 covers bytes 0–511, bank 2 covers bytes 512–1023, and the data area covers bytes 1024–1087. A page is 256 bytes and a half-page is 128 bytes. Completion and errors are reported through sticky status flags, which software clears by writing ones to a clear mask. A read port exposes the memory model.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: The mode register takes `ctl_wdata_i` on a `ctl_we_i` cycle while not busy. Its bits are: bit0 erase, bit1 program, bit2 fast-program, bit3 data-area, bit4 dual-bank. A mode write while busy is ignored.
- R2: Mode 5'b00110 (fast-program + program) takes exactly 32 word writes. The first must be on a 128-byte boundary in the program area and the rest must follow at consecutive word addresses. Once the busy period ends, the 32 words are stored in order.
- R3: An address that breaks the current operation's rule sets the alignment error flag and aborts the load, and the memory is left unchanged. The rule covers the boundary, a non-consecutive word, the wrong region or bank, and nonzero byte bits. Later window writes are then ignored and raise the write-protection flag until the mode register is written again.
- R4: Mode 5'b00011 (erase + program) takes one write on a 256-byte page boundary in the program area and sets that whole page to zero. The written value is not used.
- R5: Mode 5'b01001 (erase + data-area) takes two consecutive writes starting on an 8-byte boundary in the data area and zeroes those two words.
- R6: Mode 5'b01100 (fast-program + data-area) takes two consecutive writes starting on an 8-byte boundary in the data area. The first write is stored as the low word and the second as the high word.
- R7: Mode 5'b10011 erases one page in bank 1 and one page in bank 2. The bank-1 address must be written first.
- R8: Mode 5'b10110 takes 32 words for a bank-1 half-page followed by 32 words for a bank-2 half-page, and programs both.
- R9: `busy_o` rises in the cycle after the last word is taken. It stays high for exactly ERASE_CYCLES (erase modes) or PROG_CYCLES (program modes). At the edge where it falls, `eop_o` sets and the memory is updated.
- R10: A window write while busy, or under any other mode value, is ignored and sets `wrp_err_o`.
- R11: The flags `eop_o`, `wrp_err_o` and `pga_err_o` hold until cleared by `clr_we_i` with the matching `clr_mask_i` bit (bit0, bit1 and bit2 respectively). Bits that are not set in the mask leave their flags unchanged.
- R12: After reset the mode is zero, all flags and busy are low, and every memory word reads 32'hFFFF_FFFF.
- R13: Writing the mode register during a load discards the words collected so far, and the next write is taken as a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Mode register write strobe |
| ctl_wdata_i | input | 5 | New mode bits |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 3 | Flags to clear: bit0 end, bit1 protect, bit2 alignment |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the bus write |
| wr_data_i | input | 32 | Bus write data |
| rd_addr_i | input | ADDR_W-2 | Word index for memory read |
| rd_data_o | output | 32 | Memory word at rd_addr_i |
| mode_o | output | 5 | Current mode register |
| busy_o | output | 1 | Operation running |
| eop_o | output | 1 | Sticky end-of-operation flag |
| wrp_err_o | output | 1 | Sticky write-protection error |
| pga_err_o | output | 1 | Sticky alignment error |

## Verification
The assertions assume that a mode write and a window write never arrive in the same cycle. They also assume that a status clear never lands on the edge where an operation finishes, because in that case the flag set wins. The directed tasks drive each strobe alone, for one cycle, on the falling edge, and they wait until busy has dropped before clearing end-of-operation. The busy-length check also assumes that the two cycle parameters are the only legal run lengths, and the stimulus launches nothing while busy.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   localparam int MODE_W = 5;
   localparam int DATA_W = 32;

   localparam logic [MODE_W-1:0] MODE_PAGE_ERASE = 5'b00011;
   localparam logic [MODE_W-1:0] MODE_DUAL_ERASE = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_HALF_PROG  = 5'b00110;
   localparam logic [MODE_W-1:0] MODE_DUAL_PROG  = 5'b10110;
   localparam logic [MODE_W-1:0] MODE_DW_ERASE   = 5'b01001;
   localparam logic [MODE_W-1:0] MODE_DW_PROG    = 5'b01100;

   typedef enum logic [2:0] {
      OP_NONE, OP_PAGE_ERASE, OP_DUAL_ERASE, OP_HALF_PROG,
      OP_DUAL_PROG, OP_DW_ERASE, OP_DW_PROG
   } nvm_op_e;

   // words collected per bank segment
   function automatic int op_seg_len(nvm_op_e op, int half);
      case (op)
         OP_HALF_PROG, OP_DUAL_PROG: return half;
         OP_DW_ERASE, OP_DW_PROG:    return 2;
         default:                    return 1;
      endcase
   endfunction

   // words touched per segment; also the start alignment
   function automatic int op_span(nvm_op_e op, int half);
      case (op)
         OP_PAGE_ERASE, OP_DUAL_ERASE: return 2 * half;
         OP_HALF_PROG, OP_DUAL_PROG:   return half;
         default:                      return 2;
      endcase
   endfunction

   function automatic logic op_is_dual(nvm_op_e op);
      return (op == OP_DUAL_ERASE) || (op == OP_DUAL_PROG);
   endfunction

   function automatic logic op_is_erase(nvm_op_e op);
      return (op == OP_PAGE_ERASE) || (op == OP_DUAL_ERASE) || (op == OP_DW_ERASE);
   endfunction

   function automatic logic op_is_data(nvm_op_e op);
      return (op == OP_DW_ERASE) || (op == OP_DW_PROG);
   endfunction
endpackage

// File: rtl/nvm_mode_decode.sv
module nvm_mode_decode
   import nvm_pkg::*;
(
   input  logic [MODE_W-1:0] mode_i,
   output nvm_op_e           op_o
);
   always_comb begin
      case (mode_i)
         MODE_PAGE_ERASE: op_o = OP_PAGE_ERASE;
         MODE_DUAL_ERASE: op_o = OP_DUAL_ERASE;
         MODE_HALF_PROG:  op_o = OP_HALF_PROG;
         MODE_DUAL_PROG:  op_o = OP_DUAL_PROG;
         MODE_DW_ERASE:   op_o = OP_DW_ERASE;
         MODE_DW_PROG:    op_o = OP_DW_PROG;
         default:         op_o = OP_NONE;
      endcase
   end
endmodule

// File: rtl/nvm_load_seq.sv
module nvm_load_seq
   import nvm_pkg::*;
#(
   parameter int HALF_WORDS = 32,
   parameter int BANK_PAGES = 2,
   parameter int DATA_WORDS = 16,
   parameter int WA_W       = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  nvm_op_e                       op_i,
   input  logic                          restart_i,
   input  logic                          acc_i,
   input  logic [WA_W-1:0]               wa_i,
   input  logic                          byte_ok_i,
   input  logic [DATA_W-1:0]             data_i,
   output logic                          aborted_o,
   output logic                          pga_o,
   output logic                          launch_o,
   output nvm_op_e                       cmd_op_o,
   output logic [WA_W-1:0]               base_a_o,
   output logic [WA_W-1:0]               base_b_o,
   output logic [2*HALF_WORDS*DATA_W-1:0] buf_o
);
   localparam int PAGE_WORDS  = 2 * HALF_WORDS;
   localparam int BANK_WORDS  = PAGE_WORDS * BANK_PAGES;
   localparam int PROG_WORDS  = 2 * BANK_WORDS;
   localparam int TOTAL_WORDS = PROG_WORDS + DATA_WORDS;
   localparam int BUF_WORDS   = 2 * HALF_WORDS;
   localparam int CNT_W       = $clog2(BUF_WORDS) + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic              aborted_q;
   logic [WA_W-1:0]   base_a_q, base_b_q;
   nvm_op_e           cmd_op_q;
   logic [DATA_W-1:0] buf_q [BUF_WORDS];

   int   seg_len, total, off, lo, hi, align, wa_n;
   logic in_seg1, seg_start, ok, last;

   always_comb begin
      seg_len   = op_seg_len(op_i, HALF_WORDS);
      total     = op_is_dual(op_i) ? 2 * seg_len : seg_len;
      in_seg1   = op_is_dual(op_i) && (int'(cnt_q) >= seg_len);
      off       = in_seg1 ? int'(cnt_q) - seg_len : int'(cnt_q);
      seg_start = (off == 0);
      align     = op_span(op_i, HALF_WORDS);
      wa_n      = int'(wa_i);
      if (op_is_data(op_i)) begin
         lo = PROG_WORDS; hi = TOTAL_WORDS;
      end else if (op_is_dual(op_i)) begin
         lo = in_seg1 ? BANK_WORDS : 0;
         hi = in_seg1 ? PROG_WORDS : BANK_WORDS;
      end else begin
         lo = 0; hi = PROG_WORDS;
      end
      if (seg_start)
         ok = byte_ok_i && (wa_n >= lo) && (wa_n < hi) && (((wa_n - lo) % align) == 0);
      else
         ok = byte_ok_i && (wa_n == int'(in_seg1 ? base_b_q : base_a_q) + off);
      last = (int'(cnt_q) == total - 1);
   end

   assign pga_o     = acc_i && !restart_i && !ok;
   assign launch_o  = acc_i && !restart_i && ok && last;
   assign aborted_o = aborted_q;
   assign cmd_op_o  = cmd_op_q;
   assign base_a_o  = base_a_q;
   assign base_b_o  = base_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         aborted_q <= 1'b0;
         base_a_q  <= '0;
         base_b_q  <= '0;
         cmd_op_q  <= OP_NONE;
      end else if (restart_i) begin
         cnt_q     <= '0;
         aborted_q <= 1'b0;
      end else if (acc_i) begin
         if (!ok) begin
            aborted_q <= 1'b1;
            cnt_q     <= '0;
         end else begin
            if (seg_start) begin
               if (in_seg1) base_b_q <= wa_i;
               else         base_a_q <= wa_i;
            end
            if (last) begin
               cnt_q    <= '0;
               cmd_op_q <= op_i;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (acc_i && !restart_i && ok)
         buf_q[cnt_q[CNT_W-2:0]] <= data_i;
   end

   for (genvar g = 0; g < BUF_WORDS; g++) begin : g_buf_flat
      assign buf_o[g*DATA_W +: DATA_W] = buf_q[g];
   end
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
   parameter int PROG_CYCLES  = 20,
   parameter int ERASE_CYCLES = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   input  logic erase_i,
   output logic busy_o,
   output logic done_o
);
   localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CW      = $clog2(MAX_CYC + 1);

   logic          busy_q;
   logic [CW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rem_q  <= '0;
      end else if (launch_i) begin
         busy_q <= 1'b1;
         rem_q  <= erase_i ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
      end else if (busy_q) begin
         if (rem_q == '0) busy_q <= 1'b0;
         else             rem_q  <= rem_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (rem_q == '0);
endmodule

// File: rtl/nvm_array.sv
module nvm_array
   import nvm_pkg::*;
#(
   parameter int HALF_WORDS  = 32,
   parameter int TOTAL_WORDS = 272,
   parameter int WA_W        = 10
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           commit_i,
   input  nvm_op_e                        op_i,
   input  logic [WA_W-1:0]                base_a_i,
   input  logic [WA_W-1:0]                base_b_i,
   input  logic [2*HALF_WORDS*DATA_W-1:0] buf_i,
   input  logic [WA_W-1:0]                rd_addr_i,
   output logic [DATA_W-1:0]              rd_data_o
);
   logic [DATA_W-1:0] mem_q [TOTAL_WORDS];
   logic [DATA_W-1:0] mem_d [TOTAL_WORDS];

   always_comb begin
      int oa, ob, span;
      logic ers, dual;
      span = op_span(op_i, HALF_WORDS);
      ers  = op_is_erase(op_i);
      dual = op_is_dual(op_i);
      for (int j = 0; j < TOTAL_WORDS; j++) begin
         mem_d[j] = mem_q[j];
         oa = j - int'(base_a_i);
         ob = j - int'(base_b_i);
         if (commit_i) begin
            if (oa >= 0 && oa < span)
               mem_d[j] = ers ? '0 : buf_i[oa*DATA_W +: DATA_W];
            else if (dual && ob >= 0 && ob < span)
               mem_d[j] = ers ? '0 : buf_i[(HALF_WORDS+ob)*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < TOTAL_WORDS; j++) mem_q[j] <= '1;
      end else begin
         for (int j = 0; j < TOTAL_WORDS; j++) mem_q[j] <= mem_d[j];
      end
   end

   assign rd_data_o = (int'(rd_addr_i) < TOTAL_WORDS) ? mem_q[rd_addr_i] : '0;
endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
   import nvm_pkg::*;
#(
   parameter int HALF_WORDS   = 32,
   parameter int BANK_PAGES   = 2,
   parameter int DATA_WORDS   = 16,
   parameter int ADDR_W       = 12,
   parameter int PROG_CYCLES  = 20,
   parameter int ERASE_CYCLES = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we_i,
   input  logic [4:0]        ctl_wdata_i,
   input  logic              clr_we_i,
   input  logic [2:0]        clr_mask_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [31:0]       wr_data_i,
   input  logic [ADDR_W-3:0] rd_addr_i,
   output logic [31:0]       rd_data_o,
   output logic [4:0]        mode_o,
   output logic              busy_o,
   output logic              eop_o,
   output logic              wrp_err_o,
   output logic              pga_err_o
);
   localparam int PAGE_WORDS  = 2 * HALF_WORDS;
   localparam int BANK_WORDS  = PAGE_WORDS * BANK_PAGES;
   localparam int PROG_WORDS  = 2 * BANK_WORDS;
   localparam int TOTAL_WORDS = PROG_WORDS + DATA_WORDS;
   localparam int WA_W        = ADDR_W - 2;

   if (HALF_WORDS < 2 || (HALF_WORDS & (HALF_WORDS - 1)) != 0) begin : g_bad_half
      $error("HALF_WORDS must be a power of two of at least 2");
   end
   if (DATA_WORDS < 2 || (DATA_WORDS % 2) != 0) begin : g_bad_data
      $error("DATA_WORDS must be even and nonzero");
   end
   if (TOTAL_WORDS > (1 << WA_W)) begin : g_bad_addr
      $error("ADDR_W too small for the memory window");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_cyc
      $error("cycle counts must be at least 1");
   end

   logic [MODE_W-1:0] mode_q;
   logic              eop_q, wrp_q, pga_q;
   nvm_op_e           op, cmd_op;
   logic [WA_W-1:0]   wa, base_a, base_b;
   logic              in_win, ctl_acc, accept, reject;
   logic              aborted, pga_set, launch, busy, done;
   logic [2*HALF_WORDS*DATA_W-1:0] load_buf;

   assign wa      = wr_addr_i[ADDR_W-1:2];
   assign in_win  = wr_en_i && (int'(wa) < TOTAL_WORDS);
   assign ctl_acc = ctl_we_i && !busy;
   assign accept  = in_win && !busy && (op != OP_NONE) && !aborted;
   assign reject  = in_win && !accept;

   nvm_mode_decode u_dec (.mode_i(mode_q), .op_o(op));

   nvm_load_seq #(
      .HALF_WORDS(HALF_WORDS), .BANK_PAGES(BANK_PAGES),
      .DATA_WORDS(DATA_WORDS), .WA_W(WA_W)
   ) u_load (
      .clk(clk), .rst_n(rst_n), .op_i(op), .restart_i(ctl_acc),
      .acc_i(accept), .wa_i(wa), .byte_ok_i(wr_addr_i[1:0] == 2'b00),
      .data_i(wr_data_i), .aborted_o(aborted), .pga_o(pga_set),
      .launch_o(launch), .cmd_op_o(cmd_op), .base_a_o(base_a),
      .base_b_o(base_b), .buf_o(load_buf)
   );

   nvm_busy_timer #(
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .launch_i(launch),
      .erase_i(op_is_erase(op)), .busy_o(busy), .done_o(done)
   );

   nvm_array #(
      .HALF_WORDS(HALF_WORDS), .TOTAL_WORDS(TOTAL_WORDS), .WA_W(WA_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .commit_i(done), .op_i(cmd_op),
      .base_a_i(base_a), .base_b_i(base_b), .buf_i(load_buf),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         eop_q  <= 1'b0;
         wrp_q  <= 1'b0;
         pga_q  <= 1'b0;
      end else begin
         if (ctl_acc) mode_q <= ctl_wdata_i;
         eop_q <= done    | (eop_q & ~(clr_we_i & clr_mask_i[0]));
         wrp_q <= reject  | (wrp_q & ~(clr_we_i & clr_mask_i[1]));
         pga_q <= pga_set | (pga_q & ~(clr_we_i & clr_mask_i[2]));
      end
   end

   assign mode_o    = mode_q;
   assign busy_o    = busy;
   assign eop_o     = eop_q;
   assign wrp_err_o = wrp_q;
   assign pga_err_o = pga_q;
endmodule

// File: rtl/nvm_seq_ctrl_chk.sv
module nvm_seq_ctrl_chk #(
   parameter int ADDR_W       = 12,
   parameter int TOTAL_WORDS  = 272,
   parameter int PROG_CYCLES  = 20,
   parameter int ERASE_CYCLES = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic              clr_we_i,
   input logic [2:0]        clr_mask_i,
   input logic [4:0]        mode_o,
   input logic              busy_o,
   input logic              eop_o,
   input logic              wrp_err_o,
   input logic              pga_err_o
);
   logic [15:0] run_q;
   logic        in_win;

   assign in_win = wr_en_i && (int'(wr_addr_i[ADDR_W-1:2]) < TOTAL_WORDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (busy_o) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (mode_o == $past(mode_o))); // R1
   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (int'(run_q) == PROG_CYCLES || int'(run_q) == ERASE_CYCLES)); // R9
   AST_EOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> eop_o); // R9
   AST_WRP_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && in_win) |=> wrp_err_o); // R10
   AST_EOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_mask_i[0] && !busy_o) |=> !eop_o); // R11
   AST_PGA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pga_err_o && !(clr_we_i && clr_mask_i[2])) |=> pga_err_o); // R11
endmodule

bind nvm_seq_ctrl nvm_seq_ctrl_chk #(
   .ADDR_W(ADDR_W), .TOTAL_WORDS(TOTAL_WORDS),
   .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
   .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .mode_o(mode_o),
   .busy_o(busy_o), .eop_o(eop_o), .wrp_err_o(wrp_err_o), .pga_err_o(pga_err_o)
);

// File: tb/nvm_seq_ctrl_bench.sv
module nvm_seq_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int TOTAL      = 272;
   localparam int PROG_CYC   = 20;
   localparam int ERASE_CYC  = 30;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ctl_we = 0, clr_we = 0, wr_en = 0;
   logic [4:0]  ctl_wdata = '0;
   logic [2:0]  clr_mask = '0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [ADDR_W-3:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [4:0]  mode;
   logic        busy, eop, wrp, pga;

   int checks = 0, failures = 0;
   logic [31:0] exp_mem [TOTAL];

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_seq_ctrl u_nvm_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
      .clr_we_i(clr_we), .clr_mask_i(clr_mask), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .mode_o(mode), .busy_o(busy), .eop_o(eop),
      .wrp_err_o(wrp), .pga_err_o(pga)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic mem_chk(input string req);
      int bad = 0;
      int fi = 0;
      logic [31:0] fa = '0, fe = '0;
      for (int i = 0; i < TOTAL; i++) begin
         rd_addr = 10'(i);
         #1;
         if (rd_data !== exp_mem[i]) begin
            if (bad == 0) begin fa = rd_data; fe = exp_mem[i]; fi = i; end
            bad++;
         end
      end
      chk(bad == 0, req, $sformatf("memory word %0d", fi), fa, fe);
   endtask

   task automatic do_ctl(input logic [4:0] m);
      @(negedge clk); ctl_we = 1; ctl_wdata = m;
      @(negedge clk); ctl_we = 0;
   endtask

   task automatic do_clr(input logic [2:0] m);
      @(negedge clk); clr_we = 1; clr_mask = m;
      @(negedge clk); clr_we = 0;
   endtask

   task automatic do_wr(input int addr, input logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_addr = ADDR_W'(addr); wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wait_busy(input int exp_n, input string req);
      int n = 0;
      chk(busy === 1'b1, req, "busy after last word", 32'(busy), 1);
      while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
      chk(n == exp_n, req, "busy length", n, exp_n);
      chk(eop === 1'b1, req, "eop when busy falls", 32'(eop), 1);
   endtask

   task automatic t_reset();
      chk(mode == 5'd0, "R12", "mode", 32'(mode), 0);
      chk({busy, eop, wrp, pga} == 4'b0, "R12", "busy/flags", 32'({busy, eop, wrp, pga}), 0);
      mem_chk("R12");
   endtask

   task automatic t_half_prog();
      do_ctl(5'b00110);
      chk(mode == 5'b00110, "R1", "mode write", 32'(mode), 32'h6);
      for (int i = 0; i < 32; i++) begin
         do_wr(128 + 4*i, 32'hA000_0000 + i);
         exp_mem[32+i] = 32'hA000_0000 + i;
      end
      wait_busy(PROG_CYC, "R9");
      mem_chk("R2");
      do_clr(3'b010);
      chk(eop === 1'b1, "R11", "eop kept when unmasked", 32'(eop), 1);
      do_clr(3'b001);
      chk(eop === 1'b0, "R11", "eop cleared", 32'(eop), 0);
   endtask

   task automatic t_page_erase();
      do_ctl(5'b00011);
      do_wr(256, 32'h0);
      for (int i = 64; i < 128; i++) exp_mem[i] = '0;
      wait_busy(ERASE_CYC, "R9");
      mem_chk("R4");
      do_clr(3'b111);
   endtask

   task automatic t_dw_prog();
      do_ctl(5'b01100);
      do_wr(1032, 32'h1111_2222);
      do_wr(1036, 32'h3333_4444);
      exp_mem[258] = 32'h1111_2222; exp_mem[259] = 32'h3333_4444;
      wait_busy(PROG_CYC, "R6");
      mem_chk("R6");
      do_clr(3'b111);
   endtask

   task automatic t_dw_erase();
      do_ctl(5'b01001);
      do_wr(1040, 32'h0);
      do_wr(1044, 32'h0);
      exp_mem[260] = '0; exp_mem[261] = '0;
      wait_busy(ERASE_CYC, "R5");
      mem_chk("R5");
      do_clr(3'b111);
   endtask

   task automatic t_dual_erase();
      do_ctl(5'b10011);
      do_wr(0, 32'h0);
      chk(busy === 1'b0, "R7", "no launch after one bank", 32'(busy), 0);
      do_wr(768, 32'h0);
      for (int i = 0; i < 64; i++) begin exp_mem[i] = '0; exp_mem[192+i] = '0; end
      wait_busy(ERASE_CYC, "R7");
      mem_chk("R7");
      do_clr(3'b111);
   endtask

   task automatic t_dual_prog();
      do_ctl(5'b10110);
      for (int i = 0; i < 32; i++) begin
         do_wr(384 + 4*i, 32'hB000_0000 + i); exp_mem[96+i] = 32'hB000_0000 + i;
      end
      for (int i = 0; i < 32; i++) begin
         do_wr(512 + 4*i, 32'hD000_0000 + i); exp_mem[128+i] = 32'hD000_0000 + i;
      end
      wait_busy(PROG_CYC, "R8");
      mem_chk("R8");
      do_clr(3'b111);
   endtask

   task automatic t_align();
      do_ctl(5'b00110);
      do_wr(64, 32'h5);
      chk(pga === 1'b1, "R3", "half-page off boundary", 32'(pga), 1);
      chk(busy === 1'b0, "R3", "no busy on abort", 32'(busy), 0);
      do_wr(128, 32'h6);
      chk(wrp === 1'b1, "R3", "write after abort", 32'(wrp), 1);
      do_clr(3'b111);
      chk({wrp, pga} == 2'b00, "R11", "errors cleared", 32'({wrp, pga}), 0);
      do_ctl(5'b00110);
      do_wr(0, 32'h7); do_wr(4, 32'h8); do_wr(12, 32'h9);
      chk(pga === 1'b1, "R3", "non-consecutive word", 32'(pga), 1);
      do_clr(3'b111);
      do_ctl(5'b00110);
      do_wr(130, 32'h1);
      chk(pga === 1'b1, "R3", "byte bits nonzero", 32'(pga), 1);
      do_clr(3'b111);
      do_ctl(5'b00110);
      do_wr(1024, 32'h1);
      chk(pga === 1'b1, "R3", "program into data area", 32'(pga), 1);
      do_clr(3'b111);
      do_ctl(5'b01100);
      do_wr(1028, 32'h1);
      chk(pga === 1'b1, "R3", "double word off boundary", 32'(pga), 1);
      do_clr(3'b111);
      do_ctl(5'b10110);
      do_wr(512, 32'h1);
      chk(pga === 1'b1, "R3", "bank 2 first", 32'(pga), 1);
      do_clr(3'b111);
      mem_chk("R3");
   endtask

   task automatic t_invalid();
      do_ctl(5'b00000);
      do_wr(0, 32'h55);
      chk(wrp === 1'b1, "R10", "write with no mode", 32'(wrp), 1);
      do_clr(3'b111);
      do_ctl(5'b00111);
      do_wr(0, 32'h55);
      chk(wrp === 1'b1, "R10", "write with bad mode", 32'(wrp), 1);
      chk(busy === 1'b0, "R10", "no busy", 32'(busy), 0);
      do_clr(3'b111);
      mem_chk("R10");
   endtask

   task automatic t_busy_reject();
      do_ctl(5'b00011);
      do_wr(512, 32'h0);
      for (int i = 128; i < 192; i++) exp_mem[i] = '0;
      do_wr(0, 32'h77);
      chk(wrp === 1'b1, "R10", "write while busy", 32'(wrp), 1);
      do_ctl(5'b00110);
      chk(mode == 5'b00011, "R1", "mode write while busy", 32'(mode), 32'h3);
      while (busy === 1'b1) @(negedge clk);
      chk(eop === 1'b1, "R9", "eop after busy", 32'(eop), 1);
      mem_chk("R10");
      do_clr(3'b111);
   endtask

   task automatic t_midload();
      do_ctl(5'b00110);
      for (int i = 0; i < 10; i++) do_wr(4*i, 32'hEE00_0000 + i);
      chk(busy === 1'b0, "R13", "partial load idle", 32'(busy), 0);
      do_ctl(5'b00110);
      for (int i = 0; i < 32; i++) begin
         do_wr(4*i, 32'hC000_0000 + i); exp_mem[i] = 32'hC000_0000 + i;
      end
      chk(pga === 1'b0, "R13", "restart accepted", 32'(pga), 0);
      wait_busy(PROG_CYC, "R13");
      mem_chk("R13");
      do_clr(3'b111);
   endtask

   initial begin
      for (int i = 0; i < TOTAL; i++) exp_mem[i] = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_half_prog();
      t_page_erase();
      t_dw_prog();
      t_dw_erase();
      t_dual_erase();
      t_dual_prog();
      t_align();
      t_invalid();
      t_busy_reject();
      t_midload();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule